// File: doc/BRIEF.md
# Maskable Interrupt Status Unit with Read-to-Clear

This block is the interrupt and status section of a serial-bus controller. It holds twelve raw event flags and a mask register. From these it produces a masked status view and a single interrupt line. The protocol engine reports ten of the events as one-cycle pulses. Each of those events stays set until software clears it. Software clears one event by reading that event's own clear register, or clears all ten by reading a combined clear register. No write is needed to clear anything.

The other two events, receive-full and transmit-empty, are not pulses. They are level conditions. The block derives them from the receive and transmit queue fill levels, each compared against a threshold that software programs. They follow the fill levels on every cycle and no clear register affects them. The interrupt line is the OR of all masked status bits, and it is forced low while the controller is disabled.

Registers sit on a simple word-addressed port. A write takes effect at the clock edge. Read data is registered and appears in the cycle after the read strobe. Any clearing side effect of a read happens at that same edge.

Top module: `irq_status_unit`

## Requirements
- R1: Event bit positions are fixed: 0 rx_under, 1 rx_over, 2 rx_full, 3 tx_over, 4 tx_empty, 5 rd_req, 6 tx_abrt, 7 rx_done, 8 activity, 9 stop_det, 10 start_det, 11 gen_call. A pulse on `evt_in[i]` for a clearable bit (every bit except 2 and 4) sets raw flag i at the next clock edge.
- R2: Reading address 0x02 returns the raw flags in bits 11:0, whatever the mask holds.
- R3: Reading address 0x01 returns the raw flags ANDed with the mask. Address 0x00 holds the 12-bit mask.
- R4: Reading address 0x10+i (i from 0 to 11) returns raw flag i in bit 0. For a clearable i, the read clears flag i and only flag i.
- R5: Reading address 0x05 returns the clearable raw flags, with bits 2 and 4 read as 0, and clears every clearable flag at once.
- R6: If an event pulse arrives in the same cycle as a read that would clear that event, the flag stays set.
- R7: Bit 2 (rx_full) is 1 one cycle after `rx_level` exceeds the receive threshold at address 0x04. With the threshold at 0, a single queued byte sets it.
- R8: Bit 4 (tx_empty) is 1 one cycle after `tx_level` is at or below the transmit threshold at address 0x03.
- R9: Bits 2 and 4 ignore their `evt_in` pulses and every clear register. They follow only their level conditions.
- R10: `irq` is 1 exactly when `ctrl_en` is 1 and any masked status bit is 1. A zero mask keeps `irq` low while raw flags still accumulate.
- R11: After reset the raw flags are 0, apart from level conditions that hold, and the mask, both thresholds and `irq` are 0.
- R12: The mask and both thresholds read back what was written. Writes to the status and clear addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_en | input | 1 | Controller enabled; gates the interrupt line |
| reg_addr | input | ADDR_W (5) | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W (16) | Write data |
| reg_rd | input | 1 | Read strobe; clear registers act on it |
| reg_rdata | output | DATA_W (16) | Registered read data, valid the cycle after the strobe |
| evt_in | input | 12 | One-cycle event pulses from the protocol engine |
| tx_level | input | LVL_W (6) | Transmit queue fill level |
| rx_level | input | LVL_W (6) | Receive queue fill level |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check four behaviours on every cycle:
- A clearable flag is set one cycle after its event pulse, and a colliding clear read does not win against the pulse.
- A clearable flag falls only after a read of its own clear register or of the combined clear register.
- The two level flags track their threshold comparisons with a one-cycle lag.
- The interrupt line stays low while the controller is disabled or nothing unmasked is pending.

Other behaviours show only in the bench's directed scenarios: the exact bit positions, the register read-back values, what a clear read returns, and that writes to status addresses have no effect.

// File: rtl/irq_stat_pkg.sv
// Shared constants for the interrupt status unit: event bit positions,
// which events are clearable, and the register word addresses.
package irq_stat_pkg;

    localparam int NUM_EVT = 12;

    // Event bit positions; other blocks decode these positions.
    localparam int EV_RX_UNDER  = 0;
    localparam int EV_RX_OVER   = 1;
    localparam int EV_RX_FULL   = 2;
    localparam int EV_TX_OVER   = 3;
    localparam int EV_TX_EMPTY  = 4;
    localparam int EV_RD_REQ    = 5;
    localparam int EV_TX_ABRT   = 6;
    localparam int EV_RX_DONE   = 7;
    localparam int EV_ACTIVITY  = 8;
    localparam int EV_STOP_DET  = 9;
    localparam int EV_START_DET = 10;
    localparam int EV_GEN_CALL  = 11;

    // Every event is sticky and clearable except the two level flags.
    localparam logic [NUM_EVT-1:0] CLR_MASK =
        ~((NUM_EVT'(1) << EV_RX_FULL) | (NUM_EVT'(1) << EV_TX_EMPTY));

    // Register word addresses.
    localparam int A_MASK     = 0;
    localparam int A_MSTAT    = 1;
    localparam int A_RAW      = 2;
    localparam int A_TX_THR   = 3;
    localparam int A_RX_THR   = 4;
    localparam int A_CLR_ALL  = 5;
    localparam int A_CLR_BASE = 16;

endpackage

// File: rtl/irq_level_cmp.sv
// Threshold comparators for the two queue-level events.
// Assumes the fill levels and thresholds share one unsigned width.
module irq_level_cmp #(
    parameter int LVL_W = 6
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_thr,
    input  logic [LVL_W-1:0] rx_thr,
    output logic             rx_above,
    output logic             tx_below
);

    // Receive side fires above its threshold, transmit side at or below it.
    always_comb begin
        rx_above = (rx_level > rx_thr);
        tx_below = (tx_level <= tx_thr);
    end

endmodule

// File: rtl/irq_evt_flags.sv
// Raw event flag bank. Clearable bits are sticky: an event pulse sets the bit,
// a clear strobe resets it, and a pulse wins over a clear in the same cycle.
// Non-clearable bits register their level input every cycle.
// Assumes clr is only ever asserted for clearable bits.
module irq_evt_flags #(
    parameter int               N        = 12,
    parameter logic [N-1:0]     CLR_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] lvl_in,
    input  logic [N-1:0] clr,
    output logic [N-1:0] raw
);

    // Inputs that a bit's variant does not consume.
    logic evt_lvl_unused;
    assign evt_lvl_unused = ^(evt & ~CLR_MASK) ^ ^(lvl_in & CLR_MASK);

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (CLR_MASK[i]) begin : g_sticky
            // Sticky flag: set by a pulse, cleared by a strobe, pulse has priority.
            always_ff @(posedge clk) begin
                if (!rst_n)      raw[i] <= 1'b0;
                else if (evt[i]) raw[i] <= 1'b1;
                else if (clr[i]) raw[i] <= 1'b0;
            end
        end else begin : g_level
            // Level flag: register the comparator result.
            always_ff @(posedge clk) begin
                if (!rst_n) raw[i] <= 1'b0;
                else        raw[i] <= lvl_in[i];
            end
        end
    end

endmodule

// File: rtl/irq_regif.sv
// Register port: mask and threshold storage, registered read mux, and
// per-event clear strobes generated by reads of the clear addresses.
// Assumes DATA_W >= N and DATA_W >= LVL_W.
module irq_regif
    import irq_stat_pkg::*;
#(
    parameter int           ADDR_W   = 5,
    parameter int           DATA_W   = 16,
    parameter int           LVL_W    = 6,
    parameter int           N        = 12,
    parameter logic [N-1:0] CMASK    = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N-1:0]      raw,
    output logic [N-1:0]      mask_o,
    output logic [N-1:0]      masked_o,
    output logic [LVL_W-1:0]  tx_thr_o,
    output logic [LVL_W-1:0]  rx_thr_o,
    output logic [N-1:0]      clr_o
);

    logic [DATA_W-1:0] rd_mux;
    logic              hit_all;
    logic              wdata_unused;

    assign wdata_unused = ^reg_wdata;
    assign hit_all      = (reg_addr == ADDR_W'(A_CLR_ALL));
    assign masked_o     = raw & mask_o;

    // Writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o   <= '0;
            tx_thr_o <= '0;
            rx_thr_o <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(A_MASK))   mask_o   <= reg_wdata[N-1:0];
            if (reg_addr == ADDR_W'(A_TX_THR)) tx_thr_o <= reg_wdata[LVL_W-1:0];
            if (reg_addr == ADDR_W'(A_RX_THR)) rx_thr_o <= reg_wdata[LVL_W-1:0];
        end
    end

    // Read multiplexer over every readable address.
    always_comb begin
        rd_mux = '0;
        if (reg_addr == ADDR_W'(A_MASK))    rd_mux = DATA_W'(mask_o);
        if (reg_addr == ADDR_W'(A_MSTAT))   rd_mux = DATA_W'(masked_o);
        if (reg_addr == ADDR_W'(A_RAW))     rd_mux = DATA_W'(raw);
        if (reg_addr == ADDR_W'(A_TX_THR))  rd_mux = DATA_W'(tx_thr_o);
        if (reg_addr == ADDR_W'(A_RX_THR))  rd_mux = DATA_W'(rx_thr_o);
        if (hit_all)                        rd_mux = DATA_W'(raw & CMASK);
        for (int i = 0; i < N; i++) begin
            if (reg_addr == ADDR_W'(A_CLR_BASE + i)) rd_mux = DATA_W'(raw[i]);
        end
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    // Clear strobes: one per clearable event, from its own address or the combined one.
    for (genvar i = 0; i < N; i++) begin : g_clr
        if (CMASK[i]) begin : g_on
            assign clr_o[i] = reg_rd && (hit_all || reg_addr == ADDR_W'(A_CLR_BASE + i));
        end else begin : g_off
            assign clr_o[i] = 1'b0;
        end
    end

endmodule

// File: rtl/irq_status_unit.sv
// Top of the interrupt status unit: raw flags, threshold events, mask,
// masked status and the interrupt line gated by the controller enable.
// Assumes evt_in pulses are synchronous to clk.
module irq_status_unit
    import irq_stat_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16,
    parameter int LVL_W  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_en,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic                reg_rd,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_EVT-1:0]  evt_in,
    input  logic [LVL_W-1:0]    tx_level,
    input  logic [LVL_W-1:0]    rx_level,
    output logic                irq
);

    logic [NUM_EVT-1:0] raw_q;
    logic [NUM_EVT-1:0] mask_q;
    logic [NUM_EVT-1:0] masked;
    logic [NUM_EVT-1:0] clr_vec;
    logic [NUM_EVT-1:0] lvl_vec;
    logic [LVL_W-1:0]   tx_thr_q;
    logic [LVL_W-1:0]   rx_thr_q;
    logic               rx_above;
    logic               tx_below;

    irq_level_cmp #(.LVL_W(LVL_W)) u_cmp (
        .tx_level (tx_level),
        .rx_level (rx_level),
        .tx_thr   (tx_thr_q),
        .rx_thr   (rx_thr_q),
        .rx_above (rx_above),
        .tx_below (tx_below)
    );

    // Place the comparator results on their event positions.
    always_comb begin
        lvl_vec              = '0;
        lvl_vec[EV_RX_FULL]  = rx_above;
        lvl_vec[EV_TX_EMPTY] = tx_below;
    end

    irq_evt_flags #(.N(NUM_EVT), .CLR_MASK(CLR_MASK)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt_in),
        .lvl_in (lvl_vec),
        .clr    (clr_vec),
        .raw    (raw_q)
    );

    irq_regif #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LVL_W  (LVL_W),
        .N      (NUM_EVT),
        .CMASK  (CLR_MASK)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata),
        .raw       (raw_q),
        .mask_o    (mask_q),
        .masked_o  (masked),
        .tx_thr_o  (tx_thr_q),
        .rx_thr_o  (rx_thr_q),
        .clr_o     (clr_vec)
    );

    // Interrupt line: any masked event while the controller is enabled.
    assign irq = ctrl_en && (|masked);

endmodule

// File: rtl/irq_status_unit_chk.sv
// Cycle-by-cycle properties of the interrupt status unit, bound to its top.
module irq_status_unit_chk
    import irq_stat_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int LVL_W  = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ctrl_en,
    input logic               reg_rd,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [NUM_EVT-1:0] evt_in,
    input logic [LVL_W-1:0]   tx_level,
    input logic [LVL_W-1:0]   rx_level,
    input logic [NUM_EVT-1:0] raw,
    input logic [NUM_EVT-1:0] mask,
    input logic [LVL_W-1:0]   tx_thr,
    input logic [LVL_W-1:0]   rx_thr,
    input logic               irq
);

    assert_irq_off_when_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> !irq);

    assert_irq_off_when_nothing_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(raw & mask)) |-> !irq);

    assert_rx_full_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level > rx_thr) |=> raw[EV_RX_FULL]);

    assert_rx_full_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_level > rx_thr) |=> !raw[EV_RX_FULL]);

    assert_tx_empty_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level <= tx_thr) |=> raw[EV_TX_EMPTY]);

    assert_tx_empty_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_level <= tx_thr) |=> !raw[EV_TX_EMPTY]);

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_ev
        if (CLR_MASK[i]) begin : g_c
            assert_event_sets_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
                evt_in[i] |=> raw[i]);

            assert_pulse_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_rd && (reg_addr == ADDR_W'(A_CLR_ALL) ||
                            reg_addr == ADDR_W'(A_CLR_BASE + i)) && evt_in[i]) |=> raw[i]);

            assert_fall_only_on_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(raw[i]) && !raw[i]) |->
                ($past(reg_rd) && ($past(reg_addr) == ADDR_W'(A_CLR_ALL) ||
                                   $past(reg_addr) == ADDR_W'(A_CLR_BASE + i))));
        end
    end

endmodule

bind irq_status_unit irq_status_unit_chk #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_en  (ctrl_en),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .evt_in   (evt_in),
    .tx_level (tx_level),
    .rx_level (rx_level),
    .raw      (raw_q),
    .mask     (mask_q),
    .tx_thr   (tx_thr_q),
    .rx_thr   (rx_thr_q),
    .irq      (irq)
);

// File: tb/irq_status_unit_tb.sv
`timescale 1ns/1ps
// Directed bench for the interrupt status unit; one task per scenario.
module irq_status_unit_tb;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int LVL_W  = 6;
    localparam int A_MASK = 0, A_MSTAT = 1, A_RAW = 2, A_TXT = 3, A_RXT = 4;
    localparam int A_CALL = 5, A_CB = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctrl_en = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic              reg_rd = 1'b0;
    logic [DATA_W-1:0] reg_rdata;
    logic [11:0]       evt_in = '0;
    logic [LVL_W-1:0]  tx_level = '0;
    logic [LVL_W-1:0]  rx_level = '0;
    logic              irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    irq_status_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .evt_in(evt_in), .tx_level(tx_level),
        .rx_level(rx_level), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk); reg_addr = ADDR_W'(a); reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0; d = int'(reg_rdata);
    endtask

    task automatic rd_evt(input int a, input logic [11:0] ev, output int d);
        @(negedge clk); reg_addr = ADDR_W'(a); reg_rd = 1'b1; evt_in = ev;
        @(negedge clk); reg_rd = 1'b0; evt_in = '0; d = int'(reg_rdata);
    endtask

    task automatic wr(input int a, input int v);
        @(negedge clk); reg_addr = ADDR_W'(a); reg_wdata = DATA_W'(v); reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [11:0] ev);
        @(negedge clk); evt_in = ev;
        @(negedge clk); evt_in = '0;
    endtask

    task automatic levels(input int tl, input int rl);
        @(negedge clk); tx_level = LVL_W'(tl); rx_level = LVL_W'(rl);
        @(negedge clk);
    endtask

    task automatic clear_all();
        int d;
        rd(A_CALL, d);
    endtask

    task automatic t_reset();
        int d;
        check("R11 irq after reset", int'(irq), 0);
        rd(A_MASK, d);  check("R11 mask after reset", d, 0);
        rd(A_TXT, d);   check("R11 tx threshold after reset", d, 0);
        rd(A_RAW, d);   check("R11 raw after reset (tx_empty level holds)", d, 'h010);
    endtask

    task automatic t_order();
        int d;
        levels(20, 0);
        rd(A_RAW, d); check("R8 tx_empty low above threshold", d, 0);
        for (int i = 0; i < 12; i++) begin
            if (i != 2 && i != 4) begin
                pulse(12'(1 << i));
                rd(A_RAW, d);       check($sformatf("R1 R2 bit %0d position", i), d, 1 << i);
                rd(A_CB + i, d);    check($sformatf("R4 clear reg %0d returns flag", i), d, 1);
                rd(A_RAW, d);       check($sformatf("R4 bit %0d cleared", i), d, 0);
            end
        end
    endtask

    task automatic t_clear_one();
        int d;
        pulse(12'h00B);
        rd(A_CB + 1, d); check("R4 clear one returns 1", d, 1);
        rd(A_RAW, d);    check("R4 only bit 1 cleared", d, 'h009);
        rd(A_CB + 1, d); check("R4 second read returns 0", d, 0);
        clear_all();
    endtask

    task automatic t_masked();
        int d;
        pulse(12'hA0B);
        wr(A_MASK, 'h80A);
        rd(A_MASK, d);  check("R12 mask read-back", d, 'h80A);
        rd(A_MSTAT, d); check("R3 masked status", d, 'h80A & 'hA0B);
        rd(A_RAW, d);   check("R2 raw ignores mask", d, 'hA0B);
        wr(A_MASK, 0);
        clear_all();
    endtask

    task automatic t_clear_all();
        int d;
        pulse(12'hF0B);
        rd(A_CALL, d); check("R5 clear-all returns clearable flags", d, 'hF0B);
        rd(A_RAW, d);  check("R5 all cleared", d, 0);
    endtask

    task automatic t_same_cycle();
        int d;
        pulse(12'h001);
        rd_evt(A_CB + 9, 12'h200, d);
        rd(A_RAW, d);  check("R6 event beats own clear", d, 'h201);
        rd_evt(A_CALL, 12'h800, d);
        check("R5 clear-all read data", d, 'h201);
        rd(A_RAW, d);  check("R6 event beats clear-all", d, 'h800);
        clear_all();
    endtask

    task automatic t_rx_full();
        int d;
        wr(A_RXT, 0);
        rd(A_RAW, d); check("R7 level 0 thr 0 no rx_full", d, 0);
        levels(20, 1);
        rd(A_RAW, d); check("R7 one byte with thr 0", d, 'h004);
        wr(A_RXT, 3);
        rd(A_RXT, d); check("R12 rx threshold read-back", d, 3);
        levels(20, 3);
        rd(A_RAW, d); check("R7 level equal thr", d, 0);
        levels(20, 4);
        rd(A_RAW, d); check("R7 level above thr", d, 'h004);
        levels(20, 0);
    endtask

    task automatic t_tx_empty();
        int d;
        wr(A_TXT, 16);
        rd(A_TXT, d); check("R12 tx threshold read-back", d, 16);
        levels(17, 0);
        rd(A_RAW, d); check("R8 tx level above thr", d, 0);
        levels(16, 0);
        rd(A_RAW, d); check("R8 tx level at thr", d, 'h010);
        wr(A_TXT, 0);
        levels(20, 0);
    endtask

    task automatic t_level_sticky();
        int d;
        levels(20, 5);
        pulse(12'h014);
        rd(A_RAW, d);    check("R9 pulses on level bits ignored", d, 'h004);
        rd(A_CALL, d);   check("R9 clear-all hides level bits", d, 0);
        rd(A_RAW, d);    check("R9 rx_full survives clear-all", d, 'h004);
        rd(A_CB + 2, d); check("R9 clear reg 2 returns flag", d, 1);
        rd(A_RAW, d);    check("R9 rx_full survives own clear", d, 'h004);
        levels(20, 0);
        rd(A_RAW, d);    check("R7 rx_full drops with level", d, 0);
    endtask

    task automatic t_irq();
        int d;
        @(negedge clk); ctrl_en = 1'b1;
        pulse(12'h040);
        check("R10 zero mask silences irq", int'(irq), 0);
        rd(A_RAW, d); check("R10 raw accumulates under zero mask", d, 'h040);
        wr(A_MASK, 'h040);
        check("R10 irq on unmasked event", int'(irq), 1);
        @(negedge clk); ctrl_en = 1'b0; #1;
        check("R10 irq low while disabled", int'(irq), 0);
        @(negedge clk); ctrl_en = 1'b1; #1;
        check("R10 irq back when enabled", int'(irq), 1);
        rd(A_CB + 6, d);
        check("R10 irq drops after clear", int'(irq), 0);
        wr(A_MASK, 0);
    endtask

    task automatic t_wr_ignored();
        int d;
        pulse(12'h001);
        wr(A_RAW, 'hFFF);
        wr(A_MSTAT, 'hFFF);
        wr(A_CB, 'hFFF);
        wr(A_CALL, 'hFFF);
        rd(A_RAW, d);  check("R12 writes to status/clear ignored", d, 'h001);
        rd(A_MASK, d); check("R12 mask untouched", d, 0);
        clear_all();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_order();
        t_clear_one();
        t_masked();
        t_clear_all();
        t_same_cycle();
        t_rx_full();
        t_tx_empty();
        t_level_sticky();
        t_irq();
        t_wr_ignored();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule